// File: doc/BRIEF.md
# Video Switch Group Controller with Write-Only Serial Slave

This block sets the enables of five analog switch groups in a component video selector: luma/chroma pair 0, pair 1, pair 2, RGB-plus-blanking set 1 and RGB-plus-blanking set 2. It has two control paths, and a mode pin picks one of them.

In serial mode the block is a write-only I2C slave. It oversamples SCL and SDA on a fast system clock. It matches its own address and acknowledges it. It then loads the low five bits of every complete data byte into the enable register, until a STOP or a repeated START ends the transfer. A transfer cut short keeps the last complete byte.

In direct mode the select, SDA and SCL pins become three static control inputs. They are decoded through a fixed table, with no clocking.

Top module: `vidsw_ctrl`

## Requirements
- R1: With `mode_direct` high, `sw_en` is decoded combinationally from the code {sel_in, sda_in, scl_in}: 000→00000, 001→00001, 010→00010, 011→00100, 100→01000, 101→10000, 110→01010, 111→10100. When `mode_direct` returns low, `sw_en` shows the serial enable register again, with its contents unchanged.
- R2: In serial mode the slave answers only the byte 1,1,0,1,1,0,A0,RW sent MSB first, where A0 is the inverse of `sel_in` and RW must be 0. This is 0xDA with `sel_in`=0 and 0xD8 with `sel_in`=1.
- R3: For a matching address byte and for each data byte after it, `sda_pull` is high while SCL is high in the ninth clock. It is low again once SCL falls after that clock.
- R4: An address byte that does not match, or that has RW=1, gets no acknowledge. Data bytes that follow it get no acknowledge and leave `sw_en` unchanged.
- R5: Data byte bit mapping: bit0 = pair 0, bit1 = pair 1, bit2 = pair 2, bit3 = RGB set 1, bit4 = RGB set 2. Bits 7..5 are ignored.
- R6: Each complete data byte in one addressed transfer updates `sw_en`. The update takes effect before the acknowledge clock ends.
- R7: A STOP or a START that arrives before the eighth data bit is complete discards the partial byte. `sw_en` keeps the value of the last complete byte, and a repeated START begins a new address phase.
- R8: After reset in serial mode, `sw_en` is all zero.
- R9: `sda_pull` is never high in direct mode, and never outside an acknowledge slot.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, at least 16x the bus bit rate |
| rst_n | input | 1 | Active-low asynchronous reset |
| mode_direct | input | 1 | 1 = direct pin decode, 0 = serial control |
| sel_in | input | 1 | Address select (serial) or code bit 2 (direct) |
| scl_in | input | 1 | Bus clock (serial) or code bit 0 (direct) |
| sda_in | input | 1 | Bus data line level (serial) or code bit 1 (direct) |
| sda_pull | output | 1 | High = pull SDA low (open-drain drive) |
| sw_en | output | 5 | Switch group enables, mapping as in R5 |

## Verification
The assertions check three things on every cycle. The SDA pull is only active inside an acknowledge slot and is always off in direct mode. The enables only move in serial mode when a data byte completes. Every completed byte is followed by an acknowledge pull. Only the bench's bus scenarios can show the rest: the exact address match, including the select-pin inversion and the read bit; the bit mapping; the discard of partial bytes on STOP or repeated START; and the full direct-mode decode table.

// File: rtl/vsw_pkg.sv
package vsw_pkg;
  localparam int NUM_SW = 5;

  typedef enum logic [2:0] {
    S_IDLE, S_ADDR, S_AACK, S_DATA, S_DACK, S_SKIP
  } slv_state_t;

  // byte expected on the wire for this slave: fixed prefix, A1=0, A0=~sel, write
  function automatic logic [7:0] own_addr_byte(input logic sel);
    return {5'b11011, 1'b0, ~sel, 1'b0};
  endfunction

  // static pin code {sel, sda, scl} to switch enables
  function automatic logic [NUM_SW-1:0] direct_map(input logic [2:0] code);
    logic [NUM_SW-1:0] m;
    case (code)
      3'd1:    m = 5'b00001;
      3'd2:    m = 5'b00010;
      3'd3:    m = 5'b00100;
      3'd4:    m = 5'b01000;
      3'd5:    m = 5'b10000;
      3'd6:    m = 5'b01010;
      3'd7:    m = 5'b10100;
      default: m = 5'b00000;
    endcase
    return m;
  endfunction
endpackage

// File: rtl/vsw_line_filter.sv
module vsw_line_filter #(
  parameter int SYNC_STAGES = 2,
  parameter int TAPS        = 3
) (
  input  logic clk,
  input  logic rst_n,
  input  logic din,
  output logic dout
);
  logic [SYNC_STAGES-1:0] sync_q;
  logic [TAPS-1:0]        tap_q;
  logic                   vote;

  always_comb begin
    int n;
    n = 0;
    for (int i = 0; i < TAPS; i++) n += int'(tap_q[i]);
    vote = (n > TAPS / 2);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sync_q <= '1;
      tap_q  <= '1;
      dout   <= 1'b1;
    end else begin
      sync_q <= {sync_q[SYNC_STAGES-2:0], din};
      tap_q  <= {tap_q[TAPS-2:0], sync_q[SYNC_STAGES-1]};
      dout   <= vote;
    end
  end
endmodule

// File: rtl/vsw_i2c_wr.sv
module vsw_i2c_wr
  import vsw_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              clr,
  input  logic              scl,
  input  logic              sda,
  input  logic              sel,
  output logic              pull_q,
  output logic [NUM_SW-1:0] en_q,
  output logic              byte_done,
  output logic              ack_slot
);
  slv_state_t state;
  logic       scl_q, sda_q;
  logic [3:0] bit_cnt;
  logic [7:0] shreg;
  logic       start_ev, stop_ev, rise, fall, last_fall;

  assign start_ev  = scl && scl_q && sda_q && !sda;
  assign stop_ev   = scl && scl_q && !sda_q && sda;
  assign rise      = scl && !scl_q;
  assign fall      = !scl && scl_q;
  assign last_fall = fall && (bit_cnt == 4'd8);
  assign byte_done = (state == S_DATA) && last_fall && !clr;
  assign ack_slot  = (state == S_AACK) || (state == S_DACK);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state   <= S_IDLE;
      scl_q   <= 1'b1;
      sda_q   <= 1'b1;
      bit_cnt <= '0;
      shreg   <= '0;
      pull_q  <= 1'b0;
      en_q    <= '0;
    end else begin
      scl_q <= scl;
      sda_q <= sda;
      if (clr || stop_ev) begin
        state  <= S_IDLE;
        pull_q <= 1'b0;
      end else if (start_ev) begin
        state   <= S_ADDR;
        bit_cnt <= '0;
        pull_q  <= 1'b0;
      end else begin
        case (state)
          S_ADDR, S_DATA: begin
            if (rise) begin
              shreg   <= {shreg[6:0], sda};
              bit_cnt <= bit_cnt + 4'd1;
            end else if (last_fall) begin
              if (state == S_DATA) begin
                en_q   <= shreg[NUM_SW-1:0];
                pull_q <= 1'b1;
                state  <= S_DACK;
              end else if (shreg == own_addr_byte(sel)) begin
                pull_q <= 1'b1;
                state  <= S_AACK;
              end else begin
                state  <= S_SKIP;
              end
            end
          end
          S_AACK, S_DACK: begin
            if (fall) begin
              pull_q  <= 1'b0;
              bit_cnt <= '0;
              state   <= S_DATA;
            end
          end
          default: ;
        endcase
      end
    end
  end
endmodule

// File: rtl/vidsw_ctrl.sv
module vidsw_ctrl
  import vsw_pkg::*;
#(
  parameter int SYNC_STAGES = 2,
  parameter int FILT_TAPS   = 3
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              mode_direct,
  input  logic              sel_in,
  input  logic              scl_in,
  input  logic              sda_in,
  output logic              sda_pull,
  output logic [NUM_SW-1:0] sw_en
);
  localparam int NLINES = 2;

  logic [NLINES-1:0] raw_lines, flt_lines;
  logic [NUM_SW-1:0] ser_en;
  logic              pull_q;
  logic              byte_done;
  logic              ack_slot;

  assign raw_lines = {sda_in, scl_in};

  for (genvar g = 0; g < NLINES; g++) begin : g_filt
    vsw_line_filter #(.SYNC_STAGES(SYNC_STAGES), .TAPS(FILT_TAPS)) u_filt (
      .clk(clk), .rst_n(rst_n), .din(raw_lines[g]), .dout(flt_lines[g])
    );
  end

  vsw_i2c_wr u_slave (
    .clk(clk), .rst_n(rst_n), .clr(mode_direct),
    .scl(flt_lines[0]), .sda(flt_lines[1]), .sel(sel_in),
    .pull_q(pull_q), .en_q(ser_en), .byte_done(byte_done), .ack_slot(ack_slot)
  );

  assign sw_en    = mode_direct ? direct_map({sel_in, sda_in, scl_in}) : ser_en;
  assign sda_pull = pull_q && !mode_direct;
endmodule

// File: rtl/vsw_checker.sv
module vsw_checker #(
  parameter int W = 5
) (
  input logic         clk,
  input logic         rst_n,
  input logic         mode_direct,
  input logic         sda_pull,
  input logic [W-1:0] sw_en,
  input logic         byte_done,
  input logic         ack_slot
);
  p_pull_off_direct_r9: assert property (@(posedge clk) disable iff (!rst_n)
    mode_direct |-> !sda_pull);

  p_pull_in_ack_r3: assert property (@(posedge clk) disable iff (!rst_n)
    sda_pull |-> ack_slot);

  p_hold_between_bytes_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (!mode_direct && !byte_done) |=> (mode_direct || $stable(sw_en)));

  p_ack_after_byte_r6: assert property (@(posedge clk) disable iff (!rst_n)
    byte_done |=> (mode_direct || sda_pull));

  p_direct_groups_r1: assert property (@(posedge clk) disable iff (!rst_n)
    mode_direct |-> ($countones(sw_en) <= 2));

  p_reset_off_r8: assert property (@(posedge clk) disable iff (!rst_n)
    ($rose(rst_n) && !mode_direct) |-> (sw_en == '0));
endmodule

bind vidsw_ctrl vsw_checker #(.W(vsw_pkg::NUM_SW)) u_chk (
  .clk(clk), .rst_n(rst_n), .mode_direct(mode_direct), .sda_pull(sda_pull),
  .sw_en(sw_en), .byte_done(byte_done), .ack_slot(ack_slot)
);

// File: tb/test_vidsw_ctrl.sv
module test_vidsw_ctrl;
  localparam int CLK_NS = 10;
  localparam int H      = 20;

  typedef struct {
    logic [4:0] exp;
    string      tag;
  } exp_t;

  logic       clk = 0, rst_n = 0, mode_direct = 0, sel_in = 0;
  logic       m_scl = 1, m_sda = 1;
  logic       sda_pull;
  logic [4:0] sw_en;
  wire        sda_line = m_sda & ~sda_pull;

  int   checks = 0, errors = 0;
  bit   done = 0;
  bit   bad_pull = 0;
  exp_t sb_q[$];

  always #(CLK_NS / 2) clk = ~clk;

  vidsw_ctrl i_vidsw_ctrl (
    .clk(clk), .rst_n(rst_n), .mode_direct(mode_direct), .sel_in(sel_in),
    .scl_in(m_scl), .sda_in(sda_line), .sda_pull(sda_pull), .sw_en(sw_en)
  );

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  // monitor: pops expected items and compares against the enables
  always @(negedge clk) begin
    if (mode_direct && sda_pull) bad_pull = 1;
    if (sb_q.size() > 0) begin
      exp_t it;
      it = sb_q.pop_front();
      chk(sw_en == it.exp, it.tag, sw_en, it.exp);
    end
  end

  task automatic expect_en(input logic [4:0] e, input string tag);
    sb_q.push_back('{exp: e, tag: tag});
    while (sb_q.size() > 0) @(negedge clk);
  endtask

  task automatic waitc(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic bus_start();
    m_sda = 1; waitc(H);
    m_scl = 1; waitc(H);
    m_sda = 0; waitc(H);
    m_scl = 0; waitc(H);
  endtask

  task automatic bus_stop();
    m_sda = 0; waitc(H);
    m_scl = 1; waitc(H);
    m_sda = 1; waitc(H);
  endtask

  task automatic send_bits(input logic [7:0] b, input int n);
    for (int i = 7; i > 7 - n; i--) begin
      m_sda = b[i]; waitc(H);
      m_scl = 1;    waitc(H);
      m_scl = 0;    waitc(H);
    end
  endtask

  task automatic send_byte(input logic [7:0] b, input logic exp_ack, input string tag);
    send_bits(b, 8);
    m_sda = 1; waitc(H);
    m_scl = 1; waitc(H / 2);
    chk(sda_pull == exp_ack, {tag, " ack"}, sda_pull, exp_ack);
    waitc(H / 2);
    m_scl = 0; waitc(H);
    chk(sda_pull == 1'b0, {tag, " release R3"}, sda_pull, 0);
  endtask

  function automatic logic [4:0] ref_decode(input logic [2:0] c);
    logic [4:0] r;
    r = '0;
    if (c[2] == 1'b0) begin
      if (c[1:0] != 2'b00) r[c[1:0] - 2'd1] = 1'b1;
    end else begin
      r[3 + int'(c[0])] = 1'b1;
      if (c[1]) r[1 + int'(c[0])] = 1'b1;
    end
    return r;
  endfunction

  initial begin
    #(CLK_NS * 150000);
    if (!done) begin
      errors++;
      $display("FAIL watchdog expired");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    waitc(5);
    rst_n = 1;
    waitc(3);
    expect_en(5'b00000, "R8 reset enables off");
    chk(sda_pull == 0, "R8 reset no pull", sda_pull, 0);

    // sel=0 -> address 0xDA
    sel_in = 0;
    bus_start();
    send_byte(8'hDA, 1'b1, "R2 addr sel0");
    send_byte(8'h05, 1'b1, "R3 data ack");
    expect_en(5'b00101, "R5 data 0x05");
    send_byte(8'hE3, 1'b1, "R6 second byte");
    expect_en(5'b00011, "R5 top bits ignored R6");
    bus_stop();

    // sel=1 -> address 0xD8
    sel_in = 1;
    bus_start();
    send_byte(8'hD8, 1'b1, "R2 addr sel1");
    send_byte(8'h10, 1'b1, "R5 rgb2");
    expect_en(5'b10000, "R5 rgb2 only");
    bus_stop();

    // wrong A0 for sel=1
    bus_start();
    send_byte(8'hDA, 1'b0, "R4 wrong addr");
    send_byte(8'h1F, 1'b0, "R4 data after mismatch");
    bus_stop();
    expect_en(5'b10000, "R4 unchanged after mismatch");

    // read bit set
    bus_start();
    send_byte(8'hD9, 1'b0, "R4 read request");
    send_byte(8'h07, 1'b0, "R4 data after read");
    bus_stop();
    expect_en(5'b10000, "R4 unchanged after read");

    // abort by STOP mid byte
    bus_start();
    send_byte(8'hD8, 1'b1, "R2 addr abort test");
    send_byte(8'h0A, 1'b1, "R6 full byte");
    expect_en(5'b01010, "R6 0x0A applied");
    send_bits(8'hFF, 4);
    bus_stop();
    expect_en(5'b01010, "R7 partial byte dropped on STOP");

    // abort by repeated START mid byte
    bus_start();
    send_byte(8'hD8, 1'b1, "R2 addr rs test");
    send_bits(8'h1F, 6);
    bus_start();
    expect_en(5'b01010, "R7 partial byte dropped on START");
    send_byte(8'hD8, 1'b1, "R7 addr after repeated start");
    send_byte(8'h01, 1'b1, "R7 data after repeated start");
    expect_en(5'b00001, "R7 new transfer applied");
    bus_stop();

    // direct mode
    mode_direct = 1;
    for (int c = 0; c < 8; c++) begin
      sel_in = c[2]; m_sda = c[1]; m_scl = c[0];
      waitc(2);
      expect_en(ref_decode(3'(c)), "R1 direct decode");
    end
    m_sda = 1; m_scl = 1; sel_in = 1;
    waitc(4);
    mode_direct = 0;
    waitc(10);
    expect_en(5'b00001, "R1 serial register kept across direct mode");
    chk(bad_pull == 0, "R9 no pull in direct mode", bad_pull, 0);

    done = 1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule